// File: doc/BRIEF.md
# CPU-Cycle Interrupt Down Counter

This block is a 16-bit down counter that advances once per CPU cycle and raises a level interrupt request when a decrement brings it to zero. The CPU cycle arrives as a one-clock enable pulse, `tick`. Software programs the block through a byte-wide write port with three targets: a control byte, the low byte of the counter and the high byte of the counter. The block has no separate acknowledge. Any write to the control byte clears the request.

Counting and interrupt generation have separate enables. With counting on, each tick decrements a nonzero count. The tick that reaches zero sets the pending flag if interrupts are enabled. A tick that finds the count already at zero reloads 0xFFFF and raises nothing, so the counter wraps.

A small state machine holds the counting mode:
- **ST_STOPPED**: ticks are ignored. This is the state after reset.
- **ST_RUNNING**: ticks decrement the count.

The machine has two transitions, and both are taken only on a control-byte write. ST_STOPPED goes to ST_RUNNING when the written bit 7 is 1. ST_RUNNING goes to ST_STOPPED when the written bit 7 is 0. A control write that keeps bit 7 unchanged keeps the current state.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset, `count` reads 0xFFFF, `irq` is 0, and both counting and interrupt generation are disabled. Ticks therefore leave `count` unchanged.
- R2: A write with `wr_sel`=0 targets the control byte. Its bit 7 enables counting and its bit 0 enables interrupt generation. The other bits have no effect.
- R3: Every control-byte write clears a pending interrupt, so `irq` is 0 in the following cycle.
- R4: A write with `wr_sel`=1 replaces `count[7:0]` and keeps `count[15:8]`. A write with `wr_sel`=2 replaces `count[15:8]` and keeps `count[7:0]`.
- R5: While counting is enabled, a tick with a nonzero count decrements `count` by one. While counting is disabled, a tick has no effect.
- R6: While counting is enabled, a tick with `count`=0 reloads 0xFFFF and does not raise an interrupt.
- R7: A decrement that produces zero sets the pending flag when interrupts are enabled, and leaves it clear when interrupts are disabled.
- R8: `irq` is the pending flag, held as a level through later ticks and counter-byte writes until the next control-byte write.
- R9: When a write to a valid target (`wr_sel` 0 to 2) falls in the same cycle as a tick, the write takes effect and the tick is discarded. The count does not decrement and no interrupt is raised.
- R10: A write with `wr_sel`=3 changes no state, and a tick in the same cycle is processed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse per CPU cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 count low, 2 count high, 3 none |
| wr_data | input | 8 | Write data byte |
| irq | output | 1 | Level interrupt request (pending flag) |
| count | output | 16 | Current counter value |

## Verification
The checker checks the following on every cycle:
- the byte-lane loads and their untouched halves;
- the clearing effect of a control write;
- the holding of `irq` when no control write occurs;
- that the count stays frozen while stopped;
- single-step decrement and the zero-to-0xFFFF wrap;
- that every rising edge of `irq` follows a tick that took the count from one to zero with interrupts enabled.

Only the bench's scenarios show the rest. These are the exact expiry sequences from chosen start values, the loss of a tick colliding with a write, the ignored target code, and the behaviour with interrupts disabled.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

endpackage

// File: rtl/irqtmr_ctrl.sv
module irqtmr_ctrl
    import irqtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic run_bit,
    input  logic irq_bit,
    output logic running,
    output logic irq_en
);

    run_state_e state_q, state_d;
    logic       irq_en_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (ctrl_wr && run_bit)  state_d = ST_RUNNING;
            ST_RUNNING: if (ctrl_wr && !run_bit) state_d = ST_STOPPED;
            default:    state_d = ST_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_STOPPED;
            irq_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr) irq_en_q <= irq_bit;
        end
    end

    // outputs
    always_comb begin
        running = (state_q == ST_RUNNING);
        irq_en  = irq_en_q;
    end

endmodule

// File: rtl/irqtmr_counter.sv
module irqtmr_counter #(
    parameter int DATA_W = 8,
    parameter int LANES  = 2,
    localparam int CNT_W = DATA_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              hit_zero
);

    logic [CNT_W-1:0] next_val;

    always_comb begin
        next_val = (count == '0) ? '1 : (count - CNT_W'(1));
        hit_zero = step && (count == CNT_W'(1));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [DATA_W-1:0] lane_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          lane_q <= '1;
            else if (lane_wr[i]) lane_q <= wr_data;
            else if (step)       lane_q <= next_val[i*DATA_W +: DATA_W];
        end

        assign count[i*DATA_W +: DATA_W] = lane_q;
    end

endmodule

// File: rtl/irqtmr_pend.sv
module irqtmr_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    output logic pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pend <= 1'b0;
        else if (clr) pend <= 1'b0;
        else if (set) pend <= 1'b1;
    end

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import irqtmr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int LANES = 2,
    localparam int CNT_W = DATA_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq,
    output logic [CNT_W-1:0]  count
);

    localparam int RUN_BIT = DATA_W - 1;
    localparam int IRQ_BIT = 0;

    wr_sel_e          sel;
    logic             valid_wr;
    logic             ctrl_wr;
    logic [LANES-1:0] lane_wr;
    logic             running;
    logic             irq_en;
    logic             step;
    logic             hit_zero;

    always_comb begin
        sel      = wr_sel_e'(wr_sel);
        valid_wr = wr_en && (sel != SEL_NONE);
        ctrl_wr  = wr_en && (sel == SEL_CTRL);
        lane_wr  = {wr_en && (sel == SEL_HI), wr_en && (sel == SEL_LO)};
        // a write in the same cycle wins over the tick
        step     = tick && running && !valid_wr;
    end

    irqtmr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .run_bit (wr_data[RUN_BIT]),
        .irq_bit (wr_data[IRQ_BIT]),
        .running (running),
        .irq_en  (irq_en)
    );

    irqtmr_counter #(.DATA_W(DATA_W), .LANES(LANES)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .lane_wr  (lane_wr),
        .wr_data  (wr_data),
        .count    (count),
        .hit_zero (hit_zero)
    );

    irqtmr_pend u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl_wr),
        .set   (hit_zero && irq_en),
        .pend  (irq)
    );

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
    parameter int DATA_W = 8,
    localparam int CNT_W = DATA_W * 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic              running,
    input logic              irq_en
);

    logic ctrl_w, lo_w, hi_w, any_w;
    assign ctrl_w = wr_en && (wr_sel == 2'd0);
    assign lo_w   = wr_en && (wr_sel == 2'd1);
    assign hi_w   = wr_en && (wr_sel == 2'd2);
    assign any_w  = ctrl_w || lo_w || hi_w;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (count == '1) && !irq);

    p_ctrl_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_w |=> !irq);

    p_lo_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_w |=> (count[DATA_W-1:0] == $past(wr_data))
                 && (count[CNT_W-1:DATA_W] == $past(count[CNT_W-1:DATA_W])));

    p_hi_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_w |=> (count[CNT_W-1:DATA_W] == $past(wr_data))
                 && (count[DATA_W-1:0] == $past(count[DATA_W-1:0])));

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !lo_w && !hi_w) |=> $stable(count));

    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !any_w && count != '0) |=> count == $past(count) - CNT_W'(1));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !any_w && count == '0) |=> (count == '1) && (irq == $past(irq)));

    p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(count) == CNT_W'(1) && $past(irq_en) && $past(running)
                      && $past(tick) && !$past(any_w));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_w) |=> irq);

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .irq     (irq),
    .count   (count),
    .running (running),
    .irq_en  (irq_en)
);

// File: tb/cyc_irq_timer_tb.sv
module cyc_irq_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        irq;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cyc_irq_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq), .count(count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: drive at a falling edge, return at the next falling edge
    task automatic step(input bit we, input bit [1:0] sel, input bit [7:0] d, input bit tk);
        wr_en = we; wr_sel = sel; wr_data = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic load(input bit [15:0] v);
        step(1'b1, 2'd1, v[7:0], 1'b0);
        step(1'b1, 2'd2, v[15:8], 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 count", count, 16'hFFFF);
        chk("R1 irq", irq, 0);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R1 stopped", count, 16'hFFFF);
    endtask

    task automatic t_bytes();
        step(1'b1, 2'd1, 8'h34, 1'b0);
        chk("R4 low", count, 16'hFF34);
        step(1'b1, 2'd2, 8'h12, 1'b0);
        chk("R4 high", count, 16'h1234);
        step(1'b1, 2'd1, 8'h56, 1'b0);
        chk("R4 low keeps high", count, 16'h1256);
    endtask

    task automatic t_count_noirq();
        step(1'b1, 2'd0, 8'h80, 1'b0);       // R2: run, no irq
        load(16'h0003);
        step(1'b0, 2'd0, 8'h00, 1'b0);
        chk("R5 no tick", count, 3);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R5 dec", count, 2);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R7 reach zero", count, 0);
        chk("R7 disabled irq", irq, 0);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R6 wrap", count, 16'hFFFF);
        step(1'b1, 2'd0, 8'h7E, 1'b0);       // R2: bit7 clear stops, other bits ignored
        step(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R2 stop", count, 16'hFFFF);
    endtask

    task automatic t_irq();
        step(1'b1, 2'd0, 8'h81, 1'b0);
        load(16'h0002);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R7 not yet", irq, 0);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R7 fire", irq, 1);
        chk("R7 count", count, 0);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R6 wrap count", count, 16'hFFFF);
        chk("R8 held after wrap", irq, 1);
        step(1'b1, 2'd1, 8'h10, 1'b0);
        step(1'b1, 2'd3, 8'h00, 1'b0);
        chk("R8 held after writes", irq, 1);
        step(1'b1, 2'd0, 8'h81, 1'b0);
        chk("R3 clear", irq, 0);
        load(16'h0000);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        chk("R6 zero reload", count, 16'hFFFF);
        chk("R6 no irq", irq, 0);
    endtask

    task automatic t_priority();
        step(1'b1, 2'd0, 8'h81, 1'b0);
        load(16'h0001);
        step(1'b1, 2'd1, 8'h50, 1'b1);
        chk("R9 lo write wins", count, 16'h0050);
        chk("R9 no irq", irq, 0);
        load(16'h0001);
        step(1'b1, 2'd0, 8'h81, 1'b1);
        chk("R9 ctrl write wins", count, 1);
        chk("R9 ctrl no irq", irq, 0);
        step(1'b1, 2'd3, 8'h00, 1'b1);
        chk("R10 tick through", count, 0);
        chk("R10 irq fires", irq, 1);
        step(1'b1, 2'd3, 8'h00, 1'b0);
        chk("R10 no effect", count, 0);
        chk("R10 irq kept", irq, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_count_noirq();
        t_irq();
        t_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule